// File: doc/BRIEF.md
# Fault Spreading Blur Mask Generator

This block sits beside the round register of a duplicated cipher datapath in which one copy carries the true state and the other carries its bitwise complement. Each round, it receives the substitution-stage outputs of both copies. Each output is a 128-bit value arranged as a 4×4 matrix of bytes.

The block forms an error byte for every matrix position. That byte is zero when the two copies are exact complements and equals the injected fault value otherwise. It then XORs the errors along each row and each column. For every position it combines the row sum and the column sum of that position. The result is a mask in which a single faulty byte lands on all six other bytes of its row and column.

The mask bits are reversed inside each byte. Mask and error flag are captured on the valid strobe, so they line up with the round register. The surrounding datapath XORs the mask into the state. A faulted result is therefore scrambled, rather than muted or replaced by a constant.

Top module: `fault_spread_mask`

## Requirements
- R1: After reset, and until the first valid strobe, `blurMask` is all zero and `faultFlag` is low.
- R2: When `stateDual` is the exact bitwise complement of `stateMain` at a strobe, `blurMask` is zero and `faultFlag` is low in the following cycle. This holds even when both copies carry matching complementary faults.
- R3: One cycle after a strobe, `faultFlag` is high exactly when some position has a non-zero error byte. A low flag always comes with an all-zero mask.
- R4: Byte (i, j) occupies bits [8·(4j+i)+7 : 8·(4j+i)] of every 128-bit port. Its error byte is a = main XOR NOT dual. One cycle after a strobe, mask byte (i, j) equals the bit-reversed value of (XOR of row i errors) XOR (XOR of column j errors).
- R5: With exactly one non-zero error byte e at (i0, j0), each of the six other bytes in row i0 and column j0 receives reverse(e). Byte (i0, j0) and the nine remaining bytes receive zero.
- R6: The reversal stays inside each byte: bit k of a spread error byte appears at bit 7−k of the same mask byte.
- R7: While `inValid` is low, `blurMask` and `faultFlag` keep their values whatever the state inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Strobe: capture a new mask and flag at this edge |
| stateMain | input | 128 | Substitution output of the true-value copy |
| stateDual | input | 128 | Substitution output of the complemented copy |
| blurMask | output | 128 | Registered bit-reversed spread error mask |
| faultFlag | output | 1 | Registered indication of any byte discrepancy |

## Verification
The bench builds the block with its default parameters: a 4×4 matrix of 8-bit bytes. Under these values all sixteen single-fault positions can be swept exhaustively. Fault bytes with one bit set expose the in-byte reversal. A uniform fault over all sixteen positions makes every row and column sum cancel, which separates the flag from the mask. Random multi-fault pairs, and idle cycles with changing inputs, cover the general spreading formula and the hold behaviour.

// File: rtl/spread_pkg.sv
package spread_pkg;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic capture;   // latch new mask and flag this edge
  } spreadCtl_t;

endpackage

// File: rtl/spread_ctrl.sv
module spread_ctrl
  import spread_pkg::*;
(
  input  logic       inValid,
  output spreadCtl_t ctl
);

  // Capture is aligned with the round register load
  always_comb begin
    ctl         = '0;
    ctl.capture = inValid;
  end

endmodule

// File: rtl/spread_datapath.sv
module spread_datapath
  import spread_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  spreadCtl_t                        ctl,
  input  logic [ROWS*COLS*BYTE_W-1:0]       stateMain,
  input  logic [ROWS*COLS*BYTE_W-1:0]       stateDual,
  output logic [ROWS*COLS*BYTE_W-1:0]       blurMask,
  output logic                              faultFlag
);

  localparam int NBYTES  = ROWS * COLS;
  localparam int STATE_W = NBYTES * BYTE_W;

  logic [ROWS-1:0][COLS-1:0][BYTE_W-1:0] errMat;
  logic [ROWS-1:0][COLS-1:0][BYTE_W-1:0] spreadMat;
  logic [ROWS-1:0][BYTE_W-1:0]           rowSum;
  logic [COLS-1:0][BYTE_W-1:0]           colSum;
  logic [STATE_W-1:0]                    maskNext;
  logic [STATE_W-1:0]                    maskQ;
  logic                                  flagQ;
  logic                                  anyErr;

  // Per-byte discrepancy, spreading and in-byte bit reversal
  for (genvar gi = 0; gi < ROWS; gi++) begin : gRow
    for (genvar gj = 0; gj < COLS; gj++) begin : gCol
      localparam int BASE = (gj * ROWS + gi) * BYTE_W;
      assign errMat[gi][gj]    = stateMain[BASE +: BYTE_W] ^ ~stateDual[BASE +: BYTE_W];
      assign spreadMat[gi][gj] = rowSum[gi] ^ colSum[gj];
      for (genvar gk = 0; gk < BYTE_W; gk++) begin : gBit
        assign maskNext[BASE + gk] = spreadMat[gi][gj][BYTE_W-1-gk];
      end
    end
  end

  // Row and column XOR reductions
  always_comb begin
    rowSum = '0;
    colSum = '0;
    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < COLS; j++) begin
        rowSum[i] = rowSum[i] ^ errMat[i][j];
        colSum[j] = colSum[j] ^ errMat[i][j];
      end
    end
  end

  assign anyErr = |errMat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      flagQ <= 1'b0;
    end else if (ctl.capture) begin
      maskQ <= maskNext;
      flagQ <= anyErr;
    end
  end

  assign blurMask  = maskQ;
  assign faultFlag = flagQ;

  // R7: registers only move on the capture strobe
  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(maskQ) && $stable(flagQ)));

  // R3: flag reflects the discrepancy seen at the capture edge
  a_r3_flag_tracks_error: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (flagQ == $past(anyErr)));

  // R3: a quiet flag never comes with a non-zero mask
  a_r3_quiet_mask: assert property (@(posedge clk) disable iff (!rstN)
    !flagQ |-> (maskQ == '0));

endmodule

// File: rtl/fault_spread_mask.sv
module fault_spread_mask
  import spread_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [ROWS*COLS*BYTE_W-1:0] stateMain,
  input  logic [ROWS*COLS*BYTE_W-1:0] stateDual,
  output logic [ROWS*COLS*BYTE_W-1:0] blurMask,
  output logic                        faultFlag
);

  spreadCtl_t ctl;

  spread_ctrl u_ctrl (
    .inValid (inValid),
    .ctl     (ctl)
  );

  spread_datapath #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stateMain (stateMain),
    .stateDual (stateDual),
    .blurMask  (blurMask),
    .faultFlag (faultFlag)
  );

  // R2: complementary copies give a silent result
  a_r2_clean_pair: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (stateMain == ~stateDual)) |=> ((blurMask == '0) && !faultFlag));

endmodule

// File: tb/sim_fault_spread_mask.sv
module sim_fault_spread_mask;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] stateMain = '0;
  logic [127:0] stateDual = '1;
  logic [127:0] blurMask;
  logic         faultFlag;

  int nChecks = 0;
  int nFail   = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fault_spread_mask u0 (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .stateMain (stateMain),
    .stateDual (stateDual),
    .blurMask  (blurMask),
    .faultFlag (faultFlag)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

  function automatic int bpos(input int i, input int j);
    return 8 * (4 * j + i);
  endfunction

  function automatic logic [127:0] expMask(input logic [127:0] m, input logic [127:0] d);
    logic [7:0]   a [4][4];
    logic [7:0]   rs [4];
    logic [7:0]   cs [4];
    logic [127:0] res;
    res = '0;
    for (int i = 0; i < 4; i++) begin rs[i] = '0; cs[i] = '0; end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        a[i][j] = m[bpos(i, j) +: 8] ^ ~d[bpos(i, j) +: 8];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        rs[i] = rs[i] ^ a[i][j];
        cs[j] = cs[j] ^ a[i][j];
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        res[bpos(i, j) +: 8] = rev8(rs[i] ^ cs[j]);
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chkMask(input string req, input logic [127:0] exp);
    nChecks++;
    if (blurMask !== exp) begin
      nFail++;
      $display("FAIL %s mask act=%h exp=%h", req, blurMask, exp);
    end
  endtask

  task automatic chkFlag(input string req, input logic exp);
    nChecks++;
    if (faultFlag !== exp) begin
      nFail++;
      $display("FAIL %s flag act=%b exp=%b", req, faultFlag, exp);
    end
  endtask

  // Drive at negedge, strobe one edge, sample at the next negedge
  task automatic strobe(input logic [127:0] m, input logic [127:0] d);
    @(negedge clk);
    stateMain = m;
    stateDual = d;
    inValid   = 1'b1;
    @(negedge clk);
    inValid   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [127:0] m, f, exp;
    logic [7:0]   e;
    void'($urandom(32'd20240611));

    // R1: reset state, and no change before the first strobe
    repeat (3) @(negedge clk);
    chkMask("R1", '0);
    chkFlag("R1", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    stateMain = rnd128();
    stateDual = rnd128();
    repeat (2) @(negedge clk);
    chkMask("R1", '0);
    chkFlag("R1", 1'b0);

    // R2: exact complement, including matching complementary faults
    for (int t = 0; t < 4; t++) begin
      m = rnd128();
      strobe(m, ~m);
      chkMask("R2", '0);
      chkFlag("R2", 1'b0);
    end

    // R5: sweep every single-fault position
    for (int i0 = 0; i0 < 4; i0++)
      for (int j0 = 0; j0 < 4; j0++) begin
        m = rnd128();
        e = 8'($urandom_range(1, 255));
        f = '0;
        f[bpos(i0, j0) +: 8] = e;
        exp = '0;
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            if ((i == i0) != (j == j0)) exp[bpos(i, j) +: 8] = rev8(e);
        strobe(m, ~m ^ f);
        chkMask("R5", exp);
        chkFlag("R3", 1'b1);
      end

    // R6: one-hot fault bits land mirrored inside each byte
    for (int k = 0; k < 8; k++) begin
      m = rnd128();
      f = '0;
      f[bpos(1, 2) + k] = 1'b1;
      exp = '0;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          if ((i == 1) != (j == 2)) exp[bpos(i, j) + 7 - k] = 1'b1;
      strobe(m, ~m ^ f);
      chkMask("R6", exp);
    end

    // R3: uniform fault everywhere cancels all sums but flag stays high
    m = rnd128();
    f = {16{8'h5A}};
    strobe(m, ~m ^ f);
    chkMask("R3", '0);
    chkFlag("R3", 1'b1);

    // R7: idle cycles with moving inputs keep the outputs
    m = rnd128();
    f = '0;
    f[bpos(3, 0) +: 8] = 8'hC3;
    f[bpos(0, 1) +: 8] = 8'h11;
    strobe(m, ~m ^ f);
    exp = expMask(m, ~m ^ f);
    chkMask("R4", exp);
    for (int t = 0; t < 5; t++) begin
      stateMain = rnd128();
      stateDual = rnd128();
      @(negedge clk);
      chkMask("R7", exp);
      chkFlag("R7", 1'b1);
    end

    // R4: random multi-fault patterns and random pairs
    for (int t = 0; t < 300; t++) begin
      m = rnd128();
      if (t % 3 == 0) f = rnd128();
      else begin
        f = '0;
        for (int n = 0; n < 3; n++)
          f[8 * $urandom_range(0, 15) +: 8] = 8'($urandom());
      end
      strobe(m, ~m ^ f);
      chkMask("R4", expMask(m, ~m ^ f));
      chkFlag("R3", f != '0);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule